// File: doc/BRIEF.md
# Per-Core Debug Control and Break Decision

This block holds the debug configuration word of one processor core and decides, cycle by cycle, whether that core must be pulled into debug mode. Software writes a small set of break-enable bits and a trace-enable bit through a plain register port. The core reports trap events with their trap type, a trap-inside-trap error condition, execution of a software breakpoint instruction, and its error, halted and power-down status. The block answers with a single-cycle debug request, a halt request, an error-clear pulse and a trace-enable level.

Each break source has its own enable: any trap, only the "error" traps (every trap type except a fixed benign set), the watchpoint trap, the software breakpoint instruction, and the trap-inside-trap condition. Once a request is raised, a debug-mode flag is latched and can be read back until a resume input clears it. Two register bits are actions rather than stored values: writing 1 to the error bit pulses an error clear, and writing 1 to the halt bit pulses a halt request, but only while the core is in debug mode.

Top module: `core_dbg_ctl`

## Requirements
- R1: After reset the stored configuration bits [5:0] are 0, the debug-mode flag is 0, and the read word equals 0x080 when all status inputs are 0.
- R2: Read bit 7 is always 1, bit 8 always 0, bits 31:12 always 0; bits 9, 10 and 11 mirror `core_err`, `core_halted` and `core_pwrdn`.
- R3: With bit 4 (break on any trap) set, `dbg_req` is 1 in the same cycle as any `trap_valid`; with no enable bit matching, `dbg_req` stays 0.
- R4: With bit 5 (break on error traps) set, a trap raises `dbg_req` unless its 8-bit type is 0x03, 0x04, 0x05, 0x06, in 0x11..0x1F, or in 0x80..0xFF.
- R5: With bit 2 set, a trap of type 0x0B (watchpoint) raises `dbg_req`; other types do not.
- R6: With bit 3 set, `bkpt_insn` raises `dbg_req`; with bit 3 clear it does not.
- R7: With bit 1 set, `err_cond` (trap while traps are being handled) raises `dbg_req`.
- R8: The debug-mode flag (read bit 6) is set on the clock edge after `dbg_req`, is cleared by `resume`, and while it is 1 `dbg_req` stays 0.
- R9: A write with bit 10 = 1 drives `halt_req` high during the write cycle only if the debug-mode flag is 1.
- R10: A write with bit 9 = 1 drives `err_clr` high during the write cycle; written bits 6 and above are never stored.
- R11: `trace_en` equals stored bit 0 and does not change when the core enters debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (continuous) |
| trap_valid | input | 1 | Trap event this cycle |
| trap_tt | input | 8 | Trap type of the event |
| err_cond | input | 1 | Trap while traps are already being handled |
| bkpt_insn | input | 1 | Software breakpoint instruction executed |
| resume | input | 1 | Core leaves debug mode |
| core_err | input | 1 | Core is in error mode |
| core_halted | input | 1 | Core is halted |
| core_pwrdn | input | 1 | Core is in power-down |
| dbg_req | output | 1 | Force debug mode (one-cycle pulse) |
| halt_req | output | 1 | Halt request pulse |
| err_clr | output | 1 | Clear error and halt pulse |
| trace_en | output | 1 | Instruction trace enable |

## Verification
A wrong trap classification appears on `dbg_req` in the very cycle of the trap, so the vector table compares the request combinationally against each trap type at the edges of the benign ranges. A wrong debug-mode flag becomes visible on read bit 6 one edge after the request, and also as a request that is not suppressed or a halt write that is ignored in the following cycles. Stored configuration errors show on the read word and on `trace_en` right after the write edge.

// File: rtl/core_dbg_pkg.sv
// Shared types and bit positions of the per-core debug control word.
package core_dbg_pkg;
    // Stored configuration, MSB first: field order matches register bits 5..0.
    typedef struct packed {
        logic brk_errtrap;   // bit 5
        logic brk_anytrap;   // bit 4
        logic brk_swbp;      // bit 3
        logic brk_wpt;       // bit 2
        logic brk_err;       // bit 1
        logic trace_on;      // bit 0
    } dbg_cfg_t;

    localparam int CFG_W     = $bits(dbg_cfg_t);
    localparam int BIT_DMODE = 6;
    localparam int BIT_ONE   = 7;
    localparam int BIT_ZERO  = 8;
    localparam int BIT_ERR   = 9;
    localparam int BIT_HALT  = 10;
    localparam int BIT_PWR   = 11;
    localparam int STAT_TOP  = BIT_PWR;
endpackage

// File: rtl/dbg_trap_classify.sv
// Trap type classifier.
// Flags the watchpoint trap type and the benign trap types that the
// "error traps only" break mode skips. Assumes TT_W >= 8; upper bits
// beyond 8 must be zero for a type to match a benign code.
module dbg_trap_classify #(
    parameter int TT_W = 8
) (
    input  logic [TT_W-1:0] tt,
    output logic            is_wpt,
    output logic            is_benign
);
    localparam logic [TT_W-1:0] TT_WPT      = TT_W'(8'h0B);
    localparam logic [TT_W-1:0] TT_FIX_LO   = TT_W'(8'h03);
    localparam logic [TT_W-1:0] TT_FIX_HI   = TT_W'(8'h06);
    localparam logic [TT_W-1:0] TT_TCC_LO   = TT_W'(8'h11);
    localparam logic [TT_W-1:0] TT_TCC_HI   = TT_W'(8'h1F);
    localparam logic [TT_W-1:0] TT_SW_LO    = TT_W'(8'h80);
    localparam logic [TT_W-1:0] TT_SW_HI    = TT_W'(8'hFF);

    // Compare the type against the watchpoint code and the benign ranges.
    always_comb begin
        is_wpt    = (tt == TT_WPT);
        is_benign = ((tt >= TT_FIX_LO) && (tt <= TT_FIX_HI)) ||
                    ((tt >= TT_TCC_LO) && (tt <= TT_TCC_HI)) ||
                    ((tt >= TT_SW_LO)  && (tt <= TT_SW_HI));
    end
endmodule

// File: rtl/dbg_break_decide.sv
// Break decision.
// Combines the enabled break sources into one debug request. Assumes the
// event inputs are single-cycle pulses; no request while already in debug.
module dbg_break_decide
    import core_dbg_pkg::*;
(
    input  dbg_cfg_t cfg,
    input  logic     in_dbg,
    input  logic     trap_valid,
    input  logic     is_wpt,
    input  logic     is_benign,
    input  logic     bkpt_insn,
    input  logic     err_cond,
    output logic     req
);
    logic trap_hit;
    logic other_hit;

    // Select the trap classes that are enabled, then the non-trap sources.
    always_comb begin
        trap_hit  = trap_valid && (cfg.brk_anytrap ||
                                   (cfg.brk_errtrap && !is_benign) ||
                                   (cfg.brk_wpt && is_wpt));
        other_hit = (bkpt_insn && cfg.brk_swbp) || (err_cond && cfg.brk_err);
        req       = !in_dbg && (trap_hit || other_hit);
    end
endmodule

// File: rtl/dbg_ctl_regs.sv
// Control register and debug-mode flag.
// Stores the six configuration bits, latches debug mode one edge after a
// request, and turns writes of the error and halt bits into pulses.
// Assumes resume is not asserted together with a request.
module dbg_ctl_regs
    import core_dbg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              req,
    input  logic              resume,
    input  logic              core_err,
    input  logic              core_halted,
    input  logic              core_pwrdn,
    output dbg_cfg_t          cfg,
    output logic              dbg_mode,
    output logic [DATA_W-1:0] rdata,
    output logic              halt_req,
    output logic              err_clr
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[DATA_W-1:BIT_HALT+1], wdata[BIT_ZERO:BIT_DMODE]};

    // Store the configuration bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (we)
            cfg <= dbg_cfg_t'(wdata[CFG_W-1:0]);
    end

    // Track debug mode: set after a request, cleared by resume.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbg_mode <= 1'b0;
        else if (req)
            dbg_mode <= 1'b1;
        else if (resume)
            dbg_mode <= 1'b0;
    end

    // Turn action bits of a write into one-cycle pulses.
    always_comb begin
        err_clr  = we && wdata[BIT_ERR];
        halt_req = we && wdata[BIT_HALT] && dbg_mode;
    end

    // Assemble the read word from stored bits, status and constants.
    always_comb begin
        rdata                = '0;
        rdata[CFG_W-1:0]     = cfg;
        rdata[BIT_DMODE]     = dbg_mode;
        rdata[BIT_ONE]       = 1'b1;
        rdata[BIT_ZERO]      = 1'b0;
        rdata[BIT_ERR]       = core_err;
        rdata[BIT_HALT]      = core_halted;
        rdata[BIT_PWR]       = core_pwrdn;
    end
endmodule

// File: rtl/core_dbg_ctl.sv
// Per-core debug control top.
// Ties the trap classifier, break decision and control register together.
// Assumes all inputs are synchronous to clk and event inputs are pulses.
module core_dbg_ctl
    import core_dbg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              trap_valid,
    input  logic [TT_W-1:0]   trap_tt,
    input  logic              err_cond,
    input  logic              bkpt_insn,
    input  logic              resume,
    input  logic              core_err,
    input  logic              core_halted,
    input  logic              core_pwrdn,
    output logic              dbg_req,
    output logic              halt_req,
    output logic              err_clr,
    output logic              trace_en
);
    dbg_cfg_t cfg;
    logic     dbg_mode;
    logic     is_wpt;
    logic     is_benign;

    dbg_trap_classify #(.TT_W(TT_W)) u_class (
        .tt        (trap_tt),
        .is_wpt    (is_wpt),
        .is_benign (is_benign)
    );

    dbg_break_decide u_decide (
        .cfg        (cfg),
        .in_dbg     (dbg_mode),
        .trap_valid (trap_valid),
        .is_wpt     (is_wpt),
        .is_benign  (is_benign),
        .bkpt_insn  (bkpt_insn),
        .err_cond   (err_cond),
        .req        (dbg_req)
    );

    dbg_ctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .req         (dbg_req),
        .resume      (resume),
        .core_err    (core_err),
        .core_halted (core_halted),
        .core_pwrdn  (core_pwrdn),
        .cfg         (cfg),
        .dbg_mode    (dbg_mode),
        .rdata       (reg_rdata),
        .halt_req    (halt_req),
        .err_clr     (err_clr)
    );

    // Trace enable follows the stored bit only.
    assign trace_en = cfg.trace_on;
endmodule

// File: rtl/core_dbg_ctl_chk.sv
// Port-level checker for core_dbg_ctl, attached with bind.
module core_dbg_ctl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              resume,
    input logic              dbg_req,
    input logic              halt_req,
    input logic              trace_en
);
    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] && !reg_rdata[8] && (reg_rdata[DATA_W-1:12] == '0));

    a_r8_req_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |=> reg_rdata[6]);

    a_r8_no_req_in_dbg: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6] |-> !dbg_req);

    a_r8_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (resume && !dbg_req) |=> !reg_rdata[6]);

    a_r9_halt_in_dbg: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> reg_rdata[6]);

    a_r11_trace_bit: assert property (@(posedge clk) disable iff (!rst_n)
        trace_en == reg_rdata[0]);
endmodule

bind core_dbg_ctl core_dbg_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .resume    (resume),
    .dbg_req   (dbg_req),
    .halt_req  (halt_req),
    .trace_en  (trace_en)
);

// File: tb/core_dbg_ctl_test.sv
module core_dbg_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trap_valid = 1'b0;
    logic [7:0]  trap_tt = '0;
    logic        err_cond = 1'b0;
    logic        bkpt_insn = 1'b0;
    logic        resume = 1'b0;
    logic        core_err = 1'b0;
    logic        core_halted = 1'b0;
    logic        core_pwrdn = 1'b0;
    logic        dbg_req, halt_req, err_clr, trace_en;

    int n_chk = 0;
    int n_fail = 0;
    logic w_halt, w_clr;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_dbg_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trap_valid(trap_valid), .trap_tt(trap_tt),
        .err_cond(err_cond), .bkpt_insn(bkpt_insn), .resume(resume),
        .core_err(core_err), .core_halted(core_halted), .core_pwrdn(core_pwrdn),
        .dbg_req(dbg_req), .halt_req(halt_req), .err_clr(err_clr),
        .trace_en(trace_en)
    );

    // Vector: {cfg[5:0], trap_valid, tt[7:0], bkpt, err, expected dbg_req}
    // cfg bits: 5 error traps, 4 any trap, 3 sw bkpt, 2 watchpoint, 1 error, 0 trace
    localparam logic [17:0] VEC [NVEC] = '{
        {6'h00, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0},  // R3 nothing enabled
        {6'h10, 1'b1, 8'h05, 1'b0, 1'b0, 1'b1},  // R3 any trap
        {6'h10, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0},  // R3 no trap
        {6'h20, 1'b1, 8'h02, 1'b0, 1'b0, 1'b1},  // R4
        {6'h20, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0},  // R4 benign low
        {6'h20, 1'b1, 8'h06, 1'b0, 1'b0, 1'b0},  // R4 benign edge
        {6'h20, 1'b1, 8'h07, 1'b0, 1'b0, 1'b1},  // R4 past edge
        {6'h20, 1'b1, 8'h10, 1'b0, 1'b0, 1'b1},  // R4 below range
        {6'h20, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0},  // R4 range start
        {6'h20, 1'b1, 8'h1F, 1'b0, 1'b0, 1'b0},  // R4 range end
        {6'h20, 1'b1, 8'h20, 1'b0, 1'b0, 1'b1},  // R4 above range
        {6'h20, 1'b1, 8'h7F, 1'b0, 1'b0, 1'b1},  // R4 below high range
        {6'h20, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0},  // R4 high range
        {6'h20, 1'b1, 8'h0B, 1'b0, 1'b0, 1'b1},  // R4 watchpoint is error trap
        {6'h04, 1'b1, 8'h0B, 1'b0, 1'b0, 1'b1},  // R5 watchpoint
        {6'h04, 1'b1, 8'h0C, 1'b0, 1'b0, 1'b0},  // R5 other type
        {6'h08, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},  // R6 breakpoint
        {6'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},  // R6 disabled
        {6'h02, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},  // R7 error condition
        {6'h10, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}   // R7 disabled
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write one word; pulses are sampled during the write cycle.
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = d;
        #1;
        w_halt = halt_req;
        w_clr = err_clr;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        reg_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(reg_rdata == 32'h080, "R1 reset word", reg_rdata, 32'h080);
        check(trace_en == 1'b0 && dbg_req == 1'b0, "R1 reset outputs",
              {trace_en, dbg_req}, 0);

        // Status mirror
        core_err = 1'b1; core_halted = 1'b1; core_pwrdn = 1'b1;
        #1;
        check(reg_rdata == 32'hE80, "R2 status mirror", reg_rdata, 32'hE80);
        core_err = 1'b0; core_halted = 1'b0; core_pwrdn = 1'b0;

        // Write all ones outside debug mode
        wr(32'hFFFF_FFFF);
        check(w_halt == 1'b0, "R9 halt ignored outside debug", w_halt, 0);
        check(w_clr == 1'b1, "R10 error clear pulse", w_clr, 1);
        check(reg_rdata == 32'h0BF, "R10 only cfg stored", reg_rdata, 32'h0BF);
        check(trace_en == 1'b1, "R11 trace enable", trace_en, 1);
        wr(32'h0);
        check(w_clr == 1'b0, "R10 no pulse on zero write", w_clr, 0);
        check(reg_rdata == 32'h080, "R2 cleared cfg", reg_rdata, 32'h080);

        // Vector table: request is combinational, inputs dropped before edge
        for (int i = 0; i < NVEC; i++) begin
            wr({26'h0, VEC[i][17:12]});
            @(negedge clk);
            trap_valid = VEC[i][11];
            trap_tt    = VEC[i][10:3];
            bkpt_insn  = VEC[i][2];
            err_cond   = VEC[i][1];
            #1;
            check(dbg_req == VEC[i][0], $sformatf("R3-R7 vector %0d", i),
                  dbg_req, VEC[i][0]);
            #1;
            trap_valid = 1'b0; trap_tt = '0; bkpt_insn = 1'b0; err_cond = 1'b0;
        end
        check(reg_rdata[6] == 1'b0, "R8 no mode without edge", reg_rdata[6], 0);

        // Debug entry with trace on
        wr(32'h11);
        @(negedge clk);
        trap_valid = 1'b1; trap_tt = 8'h2A;
        #1;
        check(dbg_req == 1'b1, "R3 any trap request", dbg_req, 1);
        check(reg_rdata[6] == 1'b0, "R8 mode not yet set", reg_rdata[6], 0);
        @(posedge clk);
        #1;
        trap_valid = 1'b0;
        check(reg_rdata[6] == 1'b1, "R8 mode set after edge", reg_rdata[6], 1);
        check(trace_en == 1'b1, "R11 trace kept in debug", trace_en, 1);
        @(negedge clk);
        trap_valid = 1'b1;
        #1;
        check(dbg_req == 1'b0, "R8 no request in debug", dbg_req, 0);
        trap_valid = 1'b0;

        // Halt in debug mode
        wr(32'h411);
        check(w_halt == 1'b1, "R9 halt in debug", w_halt, 1);
        check(w_clr == 1'b0, "R10 no clear on halt write", w_clr, 0);
        check(reg_rdata == 32'h0D1, "R10 action bit not stored", reg_rdata, 32'h0D1);

        // Resume
        @(negedge clk);
        resume = 1'b1;
        @(posedge clk);
        #1;
        resume = 1'b0;
        check(reg_rdata[6] == 1'b0, "R8 resume clears mode", reg_rdata[6], 0);
        wr(32'h411);
        check(w_halt == 1'b0, "R9 halt ignored after resume", w_halt, 0);

        // Reset clears stored state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        check(reg_rdata == 32'h080, "R1 reset after use", reg_rdata, 32'h080);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule